// File: doc/BRIEF.md
# Nonvolatile Write Unlock Controller

This block sits between a CPU register bus and an on-chip nonvolatile memory and decides when a block write may begin. Software sees two registers. The control/status register holds the target selection, the erase select, the write-enable bit, the write-start bit, the read-start bit and a write-error flag. The key register stores nothing. Writes to it only feed an unlock sequence checker, and reads of it return zero.

A write begins only under three conditions. Write-enable must already be set. The value 0x55 and then the value 0xAA must have been written to the key register. The very next bus access must be a control write that sets the start bit. Once a write begins, the block holds a busy output for a fixed, parameterised number of cycles, which stands in for the memory array. During a program-memory write it also stalls the CPU. When the write completes, the block emits a one-cycle done pulse.

A pin reset or a watchdog reset that arrives during a write ends that write and sets a sticky error flag. This flag survives those warm resets. Only power-on reset, or software writing zero to the flag, clears it.

Top module: `nvm_unlock_ctrl`

## Requirements
- R1: After power-on reset (`rst`), the control register (address 0) reads 0x00, and `busy`, `cpu_stall`, `wr_done` and `rd_req` are all low.
- R2: Address 1 is the key register. It always reads 0x00, and a write to it never changes the control register.
- R3: Three bus steps start a write: key write 0x55, then key write 0xAA, then a control write with bit1 = 1. After these steps, `busy` is high for exactly BUSY_CYCLES cycles.
- R4: The start bit (bit1) has no effect unless write-enable (bit2) was already 1 before that control write. Setting both bits in one write does not start a write.
- R5: Any bus access other than the expected next step returns the sequence checker to idle, and the later start attempt then fails. This covers a wrong key value, the two keys in reverse order, a write to another address, a read of any address, and a control write without bit1.
- R6: `cpu_stall` is high for the whole write when bit7 (program target) is 1, and it stays low for a data-memory write (bit7 = 0).
- R7: When the write completes, `wr_done` pulses high for one cycle in the cycle in which `busy` first reads low. In that same cycle, bit1 reads back 0.
- R8: A pin reset (`pin_rst`) or a watchdog reset (`wdt_rst`) during a write drops `busy` at once and sets the error flag (bit3) with no done pulse. It also clears every other control bit, so the register reads 0x08.
- R9: The error flag survives warm resets. Writing 1 to bit3 neither sets it nor clears it. Writing 0 to bit3 clears it, and so does power-on reset.
- R10: Each write consumes its unlock sequence. After a write completes, a new control write with bit1 = 1 does not start a write unless both keys are written again first.
- R11: While `busy` is high, bus writes to both registers are ignored. Bit1 reads 1 and the target bits are unchanged, and a key write made during the write does not advance the sequence.
- R12: Bit0 and bit5 always read 0. A control write with bit0 = 1 raises `rd_req` for one cycle.
- R13: The outputs `sel_prog`, `sel_cfg` and `erase_mode` follow control bits 7, 6 and 4. These bits are written directly by control writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high; clears everything |
| pin_rst | input | 1 | Synchronous external-pin warm reset; aborts a write |
| wdt_rst | input | 1 | Synchronous watchdog warm reset; aborts a write |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 key |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| busy | output | 1 | Array write in progress |
| cpu_stall | output | 1 | CPU stall during a program-memory write |
| wr_done | output | 1 | One-cycle pulse when a write completes normally |
| rd_req | output | 1 | One-cycle read request |
| sel_prog | output | 1 | Program memory selected |
| sel_cfg | output | 1 | Configuration space selected |
| erase_mode | output | 1 | Erase selected |

## Verification
Some properties are checked on every cycle:
- A write begins only when the sequence checker is armed and write-enable was already set.
- Bit1 stays high for as long as `busy` is high.
- The done pulse lasts one cycle and never coincides with busy or with bit1.
- A warm reset during a write sets the error flag without a done pulse.
- The error flag rises only for that reason.

Other behaviour shows only in the bench's scenarios:
- the exact busy length;
- every way of breaking the key sequence;
- the register readback;
- the stall difference between program and data targets;
- the survival of the error flag across warm resets and its loss at power-on reset.

// File: rtl/nvu_pkg.sv
package nvu_pkg;

    localparam int DATA_W     = 8;
    localparam int BUS_ADDR_W = 2;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 8'h55;
    localparam logic [DATA_W-1:0] KEY_SECOND = 8'hAA;

    localparam int B_PROG  = 7;
    localparam int B_CFG   = 6;
    localparam int B_ERASE = 4;
    localparam int B_ERR   = 3;
    localparam int B_WREN  = 2;
    localparam int B_WR    = 1;
    localparam int B_RD    = 0;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_HALF  = 2'd1,
        SEQ_ARMED = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic prog;
        logic cfg;
        logic erase;
        logic err;
        logic wren;
        logic wr;
    } ctrl_s;

    typedef struct packed {
        logic prog;
        logic cfg;
        logic erase;
        logic err;
        logic wren;
        logic wr;
        logic rd;
    } ctrl_wdata_s;

    typedef struct packed {
        logic                  wr;
        logic                  rd;
        logic [BUS_ADDR_W-1:0] addr;
        logic [DATA_W-1:0]     data;
    } bus_req_s;

    function automatic logic [DATA_W-1:0] ctrl_to_byte(input ctrl_s c);
        logic [DATA_W-1:0] b;
        b          = '0;
        b[B_PROG]  = c.prog;
        b[B_CFG]   = c.cfg;
        b[B_ERASE] = c.erase;
        b[B_ERR]   = c.err;
        b[B_WREN]  = c.wren;
        b[B_WR]    = c.wr;
        return b;
    endfunction

    function automatic ctrl_wdata_s byte_to_fields(input logic [DATA_W-1:0] b);
        ctrl_wdata_s f;
        f.prog  = b[B_PROG];
        f.cfg   = b[B_CFG];
        f.erase = b[B_ERASE];
        f.err   = b[B_ERR];
        f.wren  = b[B_WREN];
        f.wr    = b[B_WR];
        f.rd    = b[B_RD];
        return f;
    endfunction

endpackage

// File: rtl/nvu_key_seq.sv
module nvu_key_seq
    import nvu_pkg::*;
#(
    parameter logic [BUS_ADDR_W-1:0] KEY_ADDR = 2'd1
) (
    input  logic     clk,
    input  logic     clear,
    input  logic     busy,
    input  bus_req_s req,
    output logic     armed
);

    seq_state_e state_q, state_d;
    logic       key_wr;
    logic       any_access;

    assign key_wr     = req.wr && (req.addr == KEY_ADDR);
    assign any_access = req.wr || req.rd;

    always_comb begin
        state_d = state_q;
        if (busy) begin
            state_d = SEQ_IDLE;
        end else if (any_access) begin
            unique case (state_q)
                SEQ_IDLE:  state_d = (key_wr && req.data == KEY_FIRST)  ? SEQ_HALF  : SEQ_IDLE;
                SEQ_HALF:  state_d = (key_wr && req.data == KEY_SECOND) ? SEQ_ARMED : SEQ_IDLE;
                SEQ_ARMED: state_d = SEQ_IDLE;
                default:   state_d = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (clear) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign armed = (state_q == SEQ_ARMED);

endmodule

// File: rtl/nvu_busy_timer.sv
module nvu_busy_timer #(
    parameter int BUSY_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic abort,
    input  logic start,
    output logic busy,
    output logic last,
    output logic done
);

    localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES + 1) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign last = busy && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                busy  <= 1'b0;
                cnt_q <= '0;
            end else if (start) begin
                busy  <= 1'b1;
                cnt_q <= LOAD;
            end else if (last) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else if (busy) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/nvu_ctrl_reg.sv
module nvu_ctrl_reg
    import nvu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        warm,
    input  logic        busy,
    input  logic        ctrl_wr,
    input  ctrl_wdata_s wf,
    input  logic        start,
    input  logic        finish,
    output ctrl_s       q,
    output logic        rd_req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            rd_req <= 1'b0;
        end else if (warm) begin
            q.prog  <= 1'b0;
            q.cfg   <= 1'b0;
            q.erase <= 1'b0;
            q.wren  <= 1'b0;
            q.wr    <= 1'b0;
            q.err   <= q.err | busy;
            rd_req  <= 1'b0;
        end else begin
            rd_req <= ctrl_wr && wf.rd;
            if (ctrl_wr) begin
                q.prog  <= wf.prog;
                q.cfg   <= wf.cfg;
                q.erase <= wf.erase;
                q.wren  <= wf.wren;
                if (!wf.err) begin
                    q.err <= 1'b0;
                end
            end
            if (start) begin
                q.wr <= 1'b1;
            end else if (finish) begin
                q.wr <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/nvm_unlock_ctrl.sv
module nvm_unlock_ctrl
    import nvu_pkg::*;
#(
    parameter int                    BUSY_CYCLES = 8,
    parameter logic [BUS_ADDR_W-1:0] CTRL_ADDR   = 2'd0,
    parameter logic [BUS_ADDR_W-1:0] KEY_ADDR    = 2'd1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pin_rst,
    input  logic                  wdt_rst,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  busy,
    output logic                  cpu_stall,
    output logic                  wr_done,
    output logic                  rd_req,
    output logic                  sel_prog,
    output logic                  sel_cfg,
    output logic                  erase_mode
);

    bus_req_s    req;
    ctrl_wdata_s wf;
    ctrl_s       ctrl_q;
    logic        warm_any;
    logic        key_armed;
    logic        ctrl_wr_ok;
    logic        start;
    logic        finish;

    assign req.wr   = bus_wr;
    assign req.rd   = bus_rd;
    assign req.addr = bus_addr;
    assign req.data = bus_wdata;

    assign warm_any   = pin_rst | wdt_rst;
    assign wf         = byte_to_fields(bus_wdata);
    assign ctrl_wr_ok = bus_wr && (bus_addr == CTRL_ADDR) && !busy;
    assign start      = ctrl_wr_ok && key_armed && wf.wr && ctrl_q.wren && !warm_any;

    nvu_key_seq #(
        .KEY_ADDR (KEY_ADDR)
    ) key_i (
        .clk   (clk),
        .clear (rst | warm_any),
        .busy  (busy),
        .req   (req),
        .armed (key_armed)
    );

    nvu_busy_timer #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) timer_i (
        .clk   (clk),
        .rst   (rst),
        .abort (warm_any),
        .start (start),
        .busy  (busy),
        .last  (finish),
        .done  (wr_done)
    );

    nvu_ctrl_reg ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .warm    (warm_any),
        .busy    (busy),
        .ctrl_wr (ctrl_wr_ok),
        .wf      (wf),
        .start   (start),
        .finish  (finish),
        .q       (ctrl_q),
        .rd_req  (rd_req)
    );

    assign bus_rdata  = (bus_addr == CTRL_ADDR) ? ctrl_to_byte(ctrl_q) : '0;
    assign cpu_stall  = busy && ctrl_q.prog;
    assign sel_prog   = ctrl_q.prog;
    assign sel_cfg    = ctrl_q.cfg;
    assign erase_mode = ctrl_q.erase;

endmodule

// File: rtl/nvu_checker.sv
module nvu_checker (
    input logic clk,
    input logic rst,
    input logic warm,
    input logic busy,
    input logic done,
    input logic armed,
    input logic wren,
    input logic wr_bit,
    input logic err
);

    assert_start_after_key_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(armed));

    assert_start_needs_wren_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wren));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_write_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !wr_bit));

    assert_wr_held_R11: assert property (@(posedge clk) disable iff (rst)
        busy |-> wr_bit);

    assert_abort_sets_err_R8: assert property (@(posedge clk) disable iff (rst)
        (warm && busy) |=> (err && !busy && !done));

    assert_err_source_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $past(warm && busy));

endmodule

bind nvm_unlock_ctrl nvu_checker chk_i (
    .clk    (clk),
    .rst    (rst),
    .warm   (warm_any),
    .busy   (busy),
    .done   (wr_done),
    .armed  (key_armed),
    .wren   (ctrl_q.wren),
    .wr_bit (ctrl_q.wr),
    .err    (ctrl_q.err)
);

// File: tb/nvm_unlock_ctrl_tb_top.sv
module nvm_unlock_ctrl_tb_top;

    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin_rst = 1'b0;
    logic       wdt_rst = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       busy, cpu_stall, wr_done, rd_req, sel_prog, sel_cfg, erase_mode;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    nvm_unlock_ctrl #(.BUSY_CYCLES(N)) dut_i (
        .clk(clk), .rst(rst), .pin_rst(pin_rst), .wdt_rst(wdt_rst),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .cpu_stall(cpu_stall), .wr_done(wr_done), .rd_req(rd_req),
        .sel_prog(sel_prog), .sel_cfg(sel_cfg), .erase_mode(erase_mode)
    );

    typedef struct packed {
        logic [7:0] wdata;
        logic [7:0] exp_rd;
        logic [2:0] exp_sel;
        logic       exp_rdreq;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'hFF, 8'hD4, 3'b111, 1'b1},
        '{8'h80, 8'h80, 3'b100, 1'b0},
        '{8'h40, 8'h40, 3'b010, 1'b0},
        '{8'h10, 8'h10, 3'b001, 1'b0},
        '{8'h24, 8'h04, 3'b000, 1'b0},
        '{8'h0A, 8'h00, 3'b000, 1'b0},
        '{8'h01, 8'h00, 3'b000, 1'b1},
        '{8'hC4, 8'hC4, 3'b110, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic unlock_start(input logic [7:0] c);
        wr_reg(2'd1, 8'h55);
        wr_reg(2'd1, 8'hAA);
        wr_reg(2'd0, c);
    endtask

    task automatic wait_write(input string req, input logic exp_stall, output int n);
        n = 0;
        while (busy && n < 100) begin
            if (cpu_stall !== exp_stall) chk({req, " stall"}, cpu_stall, exp_stall);
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_reg(2'd0, d);
        chk("R1 ctrl", d, 8'h00);
        chk("R1 outs", {busy, cpu_stall, wr_done, rd_req}, 4'b0000);

        // R13 R12 R9 R4 vector walk
        foreach (VECS[i]) begin
            wr_reg(2'd0, VECS[i].wdata);
            chk("R12 rd_req", rd_req, VECS[i].exp_rdreq);
            chk("R4 no start", busy, 1'b0);
            rd_reg(2'd0, d);
            chk("R13 readback", d, VECS[i].exp_rd);
            chk("R13 selects", {sel_prog, sel_cfg, erase_mode}, VECS[i].exp_sel);
        end
        chk("R12 rd_req single", rd_req, 1'b0);

        // R2 key register
        wr_reg(2'd1, 8'h55);
        rd_reg(2'd1, d);
        chk("R2 key reads zero", d, 8'h00);
        rd_reg(2'd0, d);
        chk("R2 ctrl untouched", d, 8'hC4);

        // R4 start with WREN set in same write
        wr_reg(2'd0, 8'h80);
        unlock_start(8'h86);
        chk("R4 same write", busy, 1'b0);
        rd_reg(2'd0, d);
        chk("R4 readback", d, 8'h84);

        // R3 R6 R7 program write
        unlock_start(8'h86);
        chk("R3 busy", busy, 1'b1);
        wait_write("R6", 1'b1, n);
        chk("R3 busy length", n, N);
        chk("R7 done", wr_done, 1'b1);
        chk("R7 wr bit cleared", bus_rdata, 8'h84);
        @(negedge clk);
        chk("R7 done single", wr_done, 1'b0);

        // R10 no reuse of sequence
        wr_reg(2'd0, 8'h86);
        chk("R10 no restart", busy, 1'b0);

        // R6 data target
        wr_reg(2'd0, 8'h04);
        unlock_start(8'h06);
        chk("R6 data busy", busy, 1'b1);
        wait_write("R6 data", 1'b0, n);
        chk("R6 data length", n, N);

        // R5 broken sequences
        wr_reg(2'd0, 8'h84);
        wr_reg(2'd1, 8'h55); wr_reg(2'd1, 8'hAB); wr_reg(2'd0, 8'h86);
        chk("R5 wrong value", busy, 1'b0);
        wr_reg(2'd0, 8'h84);
        wr_reg(2'd1, 8'hAA); wr_reg(2'd1, 8'h55); wr_reg(2'd0, 8'h86);
        chk("R5 reversed", busy, 1'b0);
        wr_reg(2'd0, 8'h84);
        wr_reg(2'd1, 8'h55); wr_reg(2'd2, 8'h00); wr_reg(2'd1, 8'hAA); wr_reg(2'd0, 8'h86);
        chk("R5 other register", busy, 1'b0);
        wr_reg(2'd0, 8'h84);
        wr_reg(2'd1, 8'h55); wr_reg(2'd1, 8'hAA); rd_reg(2'd0, d); wr_reg(2'd0, 8'h86);
        chk("R5 read between", busy, 1'b0);
        wr_reg(2'd0, 8'h84);
        wr_reg(2'd1, 8'h55); wr_reg(2'd1, 8'hAA); wr_reg(2'd0, 8'h84); wr_reg(2'd0, 8'h86);
        chk("R5 skipped start", busy, 1'b0);
        wr_reg(2'd0, 8'h84);
        unlock_start(8'h86);
        chk("R5 recovery", busy, 1'b1);
        wait_write("R5", 1'b1, n);

        // R11 writes ignored while busy
        unlock_start(8'h86);
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd1, 8'h55);
        rd_reg(2'd0, d);
        chk("R11 ctrl held", d, 8'h86);
        chk("R11 target held", sel_prog, 1'b1);
        wait_write("R11", 1'b1, n);
        chk("R11 done", wr_done, 1'b1);
        wr_reg(2'd1, 8'hAA); wr_reg(2'd0, 8'h86);
        chk("R11 key not advanced", busy, 1'b0);

        // R8 pin reset abort
        unlock_start(8'h86);
        repeat (3) @(negedge clk);
        pin_rst = 1'b1;
        @(negedge clk);
        pin_rst = 1'b0;
        chk("R8 busy dropped", busy, 1'b0);
        chk("R8 no done", wr_done, 1'b0);
        rd_reg(2'd0, d);
        chk("R8 err readback", d, 8'h08);
        chk("R8 no late done", wr_done, 1'b0);

        // R9 sticky error
        wdt_rst = 1'b1;
        @(negedge clk);
        wdt_rst = 1'b0;
        rd_reg(2'd0, d);
        chk("R9 survives warm", d, 8'h08);
        wr_reg(2'd0, 8'h08);
        rd_reg(2'd0, d);
        chk("R9 write one keeps", d, 8'h08);
        wr_reg(2'd0, 8'h00);
        rd_reg(2'd0, d);
        chk("R9 write zero clears", d, 8'h00);
        wr_reg(2'd0, 8'h04);
        unlock_start(8'h06);
        @(negedge clk);
        wdt_rst = 1'b1;
        @(negedge clk);
        wdt_rst = 1'b0;
        rd_reg(2'd0, d);
        chk("R8 watchdog abort", d, 8'h08);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_reg(2'd0, d);
        chk("R9 power reset clears", d, 8'h00);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule